// File: doc/BRIEF.md
# RS485 Line-Driver Enable Controller

This block sits beside a UART transmitter and decides when an RS485 transceiver may drive the differential bus. It watches the transmitter's busy indication and its end-of-character strobe. After each character it can hold the bus for a programmable gap, counted in bit periods on a bit tick. It publishes a transmitter-empty flag. In RS485 mode the driver-enable output (RTS) is the inverse of that flag, so the bus stays driven from the first bit until the gap after the last character has run out.

When the 4-bit mode field holds any other value, RTS is a registered copy of a software level input. The empty flag keeps operating in every mode. Serialisation, baud generation and reception are handled by neighbouring blocks.

Top module: `rs485_de_ctrl`

## Requirements
- R1: While reset is asserted, and on the first edge after it is released with all inputs idle, `tx_empty` is 1 and `rts` is 0.
- R2: When `mode_sel` was 4'h1 on the previous edge, `rts` equals the inverse of `tx_empty`.
- R3: On the edge after any cycle with `tx_busy` high, `tx_empty` is 0.
- R4: A cycle with `char_done` high loads the gap counter with `guard_len`. If `guard_len` is N > 0, `tx_empty` stays 0 and rises on the edge that consumes the Nth `bit_tick` after that cycle.
- R5: With `guard_len` 0 and `tx_busy` low, `tx_empty` is 1 on the edge after the `char_done` cycle.
- R6: `tx_busy` high during a gap abandons the remaining count. A later `char_done` starts a full new gap.
- R7: `guard_len` is sampled only in the `char_done` cycle. Changing it during a gap does not alter that gap.
- R8: When `char_done` and `bit_tick` fall in the same cycle, the load wins and that tick is not counted.
- R9: When `mode_sel` is not 4'h1, `rts` equals the `sw_rts` value of the previous cycle, whatever `tx_empty` is.
- R10: While `tx_empty` is 1 and neither `tx_busy` nor `char_done` is high, `tx_empty` stays 1 whatever `bit_tick` does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_sel | input | 4 | Operating mode; 4'h1 selects RS485 |
| sw_rts | input | 1 | Software RTS level used outside RS485 mode |
| tx_busy | input | 1 | Character pending or shift register active |
| char_done | input | 1 | One-cycle strobe at the end of a stop bit |
| bit_tick | input | 1 | One-cycle strobe once per bit period |
| guard_len | input | 8 | Gap length after a character, in bit periods |
| tx_empty | output | 1 | Transmitter idle and gap elapsed |
| rts | output | 1 | Line-driver enable |

## Verification
Two collisions matter. The end-of-character strobe can coincide with a bit tick, and a new busy period can begin while a gap is still counting down. The bench forces the strobe and the tick into one cycle and then counts the ticks needed before the flag rises, which shows whether the load took priority. It also raises busy halfway through a gap and checks that the following gap runs its full length. A behavioural model predicts the flag and RTS on every clock, and directed checks at these points compare both outputs against hand-computed values.

// File: rtl/rs485_de_ctrl.sv
module rs485_de_ctrl #(
  parameter int          GUARD_W    = 8,
  parameter int          MODE_W     = 4,
  parameter [MODE_W-1:0] RS485_CODE = 'h1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [MODE_W-1:0]  mode_sel,
  input  logic               sw_rts,
  input  logic               tx_busy,
  input  logic               char_done,
  input  logic               bit_tick,
  input  logic [GUARD_W-1:0] guard_len,
  output logic               tx_empty,
  output logic               rts
);

  localparam logic [GUARD_W-1:0] GZERO = '0;

  logic [GUARD_W-1:0] gap_q, gap_d;
  logic               empty_d;
  logic               rs485_on;

  assign rs485_on = (mode_sel == RS485_CODE);

  always_comb begin
    gap_d = gap_q;
    if (char_done)
      gap_d = guard_len;
    else if (tx_busy)
      gap_d = GZERO;
    else if (bit_tick && gap_q != GZERO)
      gap_d = gap_q - 1'b1;
  end

  assign empty_d = !tx_busy && !char_done ? (gap_d == GZERO)
                                          : (char_done && !tx_busy && gap_d == GZERO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q    <= GZERO;
      tx_empty <= 1'b1;
      rts      <= 1'b0;
    end else begin
      gap_q    <= gap_d;
      tx_empty <= empty_d;
      rts      <= rs485_on ? !empty_d : sw_rts;
    end
  end

endmodule

// File: rtl/rs485_de_ctrl_chk.sv
module rs485_de_ctrl_chk #(
  parameter int          GUARD_W    = 8,
  parameter int          MODE_W     = 4,
  parameter [MODE_W-1:0] RS485_CODE = 'h1
) (
  input logic               clk,
  input logic               rst_n,
  input logic [MODE_W-1:0]  mode_sel,
  input logic               sw_rts,
  input logic               tx_busy,
  input logic               char_done,
  input logic               bit_tick,
  input logic [GUARD_W-1:0] guard_len,
  input logic               tx_empty,
  input logic               rts
);

  AST_RTS_INVERSE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == RS485_CODE) |=> (rts == !tx_empty)); // R2

  AST_BUSY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy |=> !tx_empty); // R3

  AST_GAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (char_done && guard_len != '0) |=> !tx_empty); // R4

  AST_ZERO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (char_done && guard_len == '0 && !tx_busy) |=> tx_empty); // R5

  AST_SW_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel != RS485_CODE) |=> (rts == $past(sw_rts))); // R9

  AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_empty && !tx_busy && !char_done) |=> tx_empty); // R10

endmodule

bind rs485_de_ctrl rs485_de_ctrl_chk #(
  .GUARD_W(GUARD_W), .MODE_W(MODE_W), .RS485_CODE(RS485_CODE)
) i_chk (
  .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .sw_rts(sw_rts),
  .tx_busy(tx_busy), .char_done(char_done), .bit_tick(bit_tick),
  .guard_len(guard_len), .tx_empty(tx_empty), .rts(rts)
);

// File: tb/test_rs485_de_ctrl.sv
`timescale 1ns/1ps
module test_rs485_de_ctrl;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [3:0] mode_sel = 4'h1;
  logic       sw_rts = 0, tx_busy = 0, char_done = 0, bit_tick = 0;
  logic [7:0] guard_len = 0;
  logic       tx_empty, rts;

  int checks = 0, errors = 0, cycles = 0;
  string cur_req = "R1";

  int m_gap = 0;
  bit m_empty = 1, m_rts = 0;

  always #2.5 clk = ~clk;

  rs485_de_ctrl i_rs485_de_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .sw_rts(sw_rts),
    .tx_busy(tx_busy), .char_done(char_done), .bit_tick(bit_tick),
    .guard_len(guard_len), .tx_empty(tx_empty), .rts(rts)
  );

  // behavioural reference, one update per clock
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_gap = 0; m_empty = 1; m_rts = 0;
    end else begin
      if (char_done) m_gap = guard_len;
      else if (tx_busy) m_gap = 0;
      else if (bit_tick && m_gap > 0) m_gap = m_gap - 1;
      m_empty = !tx_busy && (m_gap == 0);
      m_rts = (mode_sel == 4'h1) ? !m_empty : sw_rts;
    end
  end

  task automatic check(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    check(cur_req, "model tx_empty", tx_empty, m_empty);
    check(cur_req, "model rts", rts, m_rts);
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic cyc(bit b, bit d, bit t);
    tx_busy = b; char_done = d; bit_tick = t;
    @(posedge clk); @(negedge clk);
    tx_busy = 0; char_done = 0; bit_tick = 0;
  endtask

  task automatic send(int n);
    for (int i = 0; i < n; i++) cyc(1, 0, i % 2);
  endtask

  initial begin
    @(negedge clk);
    check("R1", "reset tx_empty", tx_empty, 1'b1);
    check("R1", "reset rts", rts, 1'b0);
    @(negedge clk); rst_n = 1;
    cyc(0, 0, 0);
    check("R1", "post-reset tx_empty", tx_empty, 1'b1);
    check("R1", "post-reset rts", rts, 1'b0);

    cur_req = "R10";
    for (int i = 0; i < 4; i++) cyc(0, 0, 1);
    check("R10", "idle ticks keep empty", tx_empty, 1'b1);

    cur_req = "R3";
    cyc(1, 0, 0);
    check("R3", "busy clears empty", tx_empty, 1'b0);
    check("R2", "rts high while busy", rts, 1'b1);

    cur_req = "R5";
    guard_len = 0; send(3); cyc(0, 1, 0);
    check("R5", "zero gap empty", tx_empty, 1'b1);
    check("R2", "rts low after zero gap", rts, 1'b0);

    cur_req = "R4";
    guard_len = 3; send(4); cyc(0, 1, 0);
    cyc(0, 0, 0); cyc(0, 0, 1); cyc(0, 0, 0); cyc(0, 0, 1);
    check("R4", "two of three ticks", tx_empty, 1'b0);
    check("R2", "rts held in gap", rts, 1'b1);
    cyc(0, 0, 1);
    check("R4", "third tick ends gap", tx_empty, 1'b1);
    check("R2", "rts drops at gap end", rts, 1'b0);

    cur_req = "R8";
    guard_len = 2; send(2); cyc(0, 1, 1);
    cyc(0, 0, 1);
    check("R8", "tick with strobe not counted", tx_empty, 1'b0);
    cyc(0, 0, 1);
    check("R8", "gap ends after two more ticks", tx_empty, 1'b1);

    cur_req = "R6";
    guard_len = 4; send(2); cyc(0, 1, 0);
    cyc(0, 0, 1); cyc(0, 0, 1);
    cyc(1, 0, 1); cyc(1, 0, 0);
    check("R6", "busy inside gap", tx_empty, 1'b0);
    cyc(0, 1, 0);
    for (int i = 0; i < 3; i++) cyc(0, 0, 1);
    check("R6", "restarted gap still running", tx_empty, 1'b0);
    cyc(0, 0, 1);
    check("R6", "restarted gap full length", tx_empty, 1'b1);

    cur_req = "R7";
    guard_len = 2; send(2); cyc(0, 1, 0);
    guard_len = 9;
    cyc(0, 0, 1); cyc(0, 0, 1);
    check("R7", "length change ignored mid gap", tx_empty, 1'b1);

    cur_req = "R9";
    mode_sel = 4'h0; sw_rts = 1; cyc(0, 0, 0);
    check("R9", "sw level high while empty", rts, 1'b1);
    guard_len = 3; send(2);
    sw_rts = 0; cyc(1, 0, 0);
    check("R9", "sw level low while busy", rts, 1'b0);
    check("R9", "empty still tracks busy", tx_empty, 1'b0);
    mode_sel = 4'h2; sw_rts = 1; cyc(0, 1, 0);
    check("R9", "mode 2 follows sw", rts, 1'b1);
    mode_sel = 4'h1; cyc(0, 0, 0);
    check("R2", "back in RS485 gap drives", rts, 1'b1);
    for (int i = 0; i < 3; i++) cyc(0, 0, 1);
    check("R2", "RS485 releases after gap", rts, 1'b0);

    cur_req = "R1";
    rst_n = 0; @(negedge clk);
    check("R1", "mid-run reset empty", tx_empty, 1'b1);
    check("R1", "mid-run reset rts", rts, 1'b0);
    rst_n = 1; cyc(0, 0, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule